// File: doc/BRIEF.md
# Hobby Motor Controller Throttle Pulse Generator

This block drives the single command line of a radio-control style brushless motor speed controller. It emits one high pulse per fixed-length frame. The pulse width encodes throttle: a minimum width means stop, a maximum width means full speed, and widths in between scale linearly with an 8-bit throttle request.

The block does not pass the request straight through. After reset, and each time it is enabled, it first sends a run of stop-width pulses. The speed controller needs these before it will accept any other command. When the rotor is at rest and a non-zero speed is requested, the block sends a few pulses at a fixed high width to break the loaded rotor loose. It then drops to the requested width and from there moves the width toward the request by a bounded amount per frame. A large sudden change would make the speed controller draw too much current.

All timing is counted in clock cycles from microsecond parameters. A new width only ever takes effect at a frame boundary.

Top module: `esc_pulse_gen`

## Requirements
- R1: While enabled, consecutive pulse rising edges are exactly FRAME_US*CYC_PER_US cycles apart.
- R2: The target width in cycles for throttle t (0..255) is MIN_US*CYC_PER_US + floor((t*SPAN_US*CYC_PER_US + 127)/255). Throttle 0 gives the stop width and 255 gives the full width.
- R3: After reset or a rising enable, the first ARM_FRAMES pulses have the stop width, whatever the throttle input does.
- R4: When arming ends with a target above the stop width, the next KICK_FRAMES pulses have width KICK_US*CYC_PER_US. When arming ends with the target at the stop width, the block runs at the stop width and does not kick.
- R5: The first pulse after the kick phase has width min(target, kick width).
- R6: Outside arming and kick, the width changes by at most STEP_US*CYC_PER_US per frame, in either direction, and settles exactly on the target.
- R7: While running at the stop width, a target above the stop width starts a new kick phase.
- R8: The width of each pulse equals the width_o value reported while that pulse is high. A width change is applied only at the end of a frame.
- R9: With the enable input low, pulse_o stays low, busy_o is 0 and width_o reads the stop width. Raising the enable restarts arming.
- R10: busy_o is 1 exactly during arming and kick frames.
- R11: After reset, with the enable input low, pulse_o is 0, busy_o is 0 and width_o reads the stop width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable. Low stops pulses; a rising edge starts arming |
| throttle_i | input | 8 | Requested throttle; 0 = stop, 255 = full |
| pulse_o | output | 1 | Registered command pulse line |
| busy_o | output | 1 | High during arming and kick frames |
| width_o | output | WW (22 by default) | Pulse width in cycles applied in the current frame |

## Verification
The bench uses a scaled configuration with one cycle per microsecond and a 64-cycle frame. It drives a full-throttle request during arming, which must be ignored. It then requests a low speed from rest, which separates the kick and the drop-back. A jump to full throttle and then to zero exposes any ramp step larger than the limit in each direction. An ascending sweep over all 256 throttle codes checks the rounding of the linear map at every value and triggers the re-kick from the stop width. Dropping the enable mid-run, holding it low and raising it again shows that the output goes quiet and that arming restarts.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_ARM  = 2'd1,
    PH_KICK = 2'd2,
    PH_RUN  = 2'd3
  } esc_phase_e;
endpackage

// File: rtl/esc_frame_timer.sv
module esc_frame_timer #(
  parameter int FRAME_CYC = 2500000,
  parameter int WW        = $clog2(FRAME_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  output logic [WW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [WW-1:0] LAST = WW'(FRAME_CYC - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == LAST);

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (cnt_q == '0));
endmodule

// File: rtl/esc_throttle_map.sv
module esc_throttle_map #(
  parameter int MIN_CYC  = 125000,
  parameter int SPAN_CYC = 125000,
  parameter int WW       = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    thr_i,
  output logic [WW-1:0] tgt_o
);
  localparam logic [WW-1:0] NEUT = WW'(MIN_CYC);

  logic [31:0]   prod;
  logic [WW-1:0] tgt_d;
  logic [WW-1:0] tgt_q;

  always_comb begin
    prod  = 32'(thr_i) * 32'(SPAN_CYC) + 32'd127;
    tgt_d = NEUT + WW'(prod / 32'd255);
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_q <= NEUT;
    else     tgt_q <= tgt_d;
  end

  assign tgt_o = tgt_q;

  a_r2_tgt_bounds: assert property (@(posedge clk) disable iff (rst)
    (tgt_q >= NEUT) && (int'(tgt_q) <= MIN_CYC + SPAN_CYC));
endmodule

// File: rtl/esc_sequencer.sv
module esc_sequencer
  import esc_pkg::*;
#(
  parameter int NEUT_CYC    = 125000,
  parameter int KICK_CYC    = 187500,
  parameter int STEP_CYC    = 2500,
  parameter int ARM_FRAMES  = 50,
  parameter int KICK_FRAMES = 10,
  parameter int WW          = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          frame_end_i,
  input  logic [WW-1:0] tgt_i,
  output esc_phase_e    phase_o,
  output logic [WW-1:0] width_o,
  output logic          busy_o
);
  localparam int NMAX = (ARM_FRAMES > KICK_FRAMES) ? ARM_FRAMES : KICK_FRAMES;
  localparam int NW   = $clog2(NMAX + 1);
  localparam logic [NW-1:0] ARM_LAST  = NW'(ARM_FRAMES - 1);
  localparam logic [NW-1:0] KICK_LAST = NW'(KICK_FRAMES - 1);
  localparam logic [WW-1:0] NEUT = WW'(NEUT_CYC);
  localparam logic [WW-1:0] KICK = WW'(KICK_CYC);
  localparam logic [WW-1:0] STEP = WW'(STEP_CYC);

  esc_phase_e    st_q, st_d;
  logic [WW-1:0] w_q, w_d;
  logic [NW-1:0] n_q, n_d;
  logic          busy_q;

  always_comb begin
    st_d = st_q;
    w_d  = w_q;
    n_d  = n_q;
    if (!en_i) begin
      st_d = PH_OFF;
      w_d  = NEUT;
      n_d  = '0;
    end else begin
      case (st_q)
        PH_OFF: begin
          st_d = PH_ARM;
          w_d  = NEUT;
          n_d  = '0;
        end
        PH_ARM: begin
          if (frame_end_i) begin
            if (n_q == ARM_LAST) begin
              n_d = '0;
              if (tgt_i > NEUT) begin
                st_d = PH_KICK;
                w_d  = KICK;
              end else begin
                st_d = PH_RUN;
                w_d  = NEUT;
              end
            end else begin
              n_d = n_q + 1'b1;
            end
          end
        end
        PH_KICK: begin
          if (frame_end_i) begin
            if (n_q == KICK_LAST) begin
              n_d  = '0;
              st_d = PH_RUN;
              w_d  = (tgt_i < KICK) ? tgt_i : KICK;
            end else begin
              n_d = n_q + 1'b1;
            end
          end
        end
        default: begin
          if (frame_end_i) begin
            if ((w_q == NEUT) && (tgt_i > NEUT)) begin
              st_d = PH_KICK;
              w_d  = KICK;
              n_d  = '0;
            end else if (tgt_i > w_q) begin
              w_d = ((tgt_i - w_q) > STEP) ? (w_q + STEP) : tgt_i;
            end else begin
              w_d = ((w_q - tgt_i) > STEP) ? (w_q - STEP) : tgt_i;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_OFF;
      w_q    <= NEUT;
      n_q    <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      w_q    <= w_d;
      n_q    <= n_d;
      busy_q <= (st_d == PH_ARM) || (st_d == PH_KICK);
    end
  end

  assign phase_o = st_q;
  assign width_o = w_q;
  assign busy_o  = busy_q;

  a_r3_arm_neutral: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_ARM) |-> (w_q == NEUT));

  a_r6_step_limit: assert property (@(posedge clk) disable iff (rst)
    (en_i && frame_end_i && (st_q == PH_RUN) && !((w_q == NEUT) && (tgt_i > NEUT)))
    |=> ((int'(w_q) <= int'($past(w_q)) + STEP_CYC) &&
         (int'(w_q) + STEP_CYC >= int'($past(w_q)))));

  a_r8_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
    (en_i && !frame_end_i && (st_q != PH_OFF)) |=> $stable(w_q));

  a_r4_kick_entry: assert property (@(posedge clk) disable iff (rst)
    (en_i && frame_end_i && (st_q == PH_ARM) && (n_q == ARM_LAST) && (tgt_i > NEUT))
    |=> ((st_q == PH_KICK) && (w_q == KICK)));
endmodule

// File: rtl/esc_pulse_gen.sv
module esc_pulse_gen
  import esc_pkg::*;
#(
  parameter int CYC_PER_US  = 125,
  parameter int FRAME_US    = 20000,
  parameter int MIN_US      = 1000,
  parameter int SPAN_US     = 1000,
  parameter int KICK_US     = 1500,
  parameter int STEP_US     = 20,
  parameter int ARM_FRAMES  = 50,
  parameter int KICK_FRAMES = 10,
  parameter int WW          = $clog2(FRAME_US * CYC_PER_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [7:0]    throttle_i,
  output logic          pulse_o,
  output logic          busy_o,
  output logic [WW-1:0] width_o
);
  localparam int FRAME_CYC = FRAME_US * CYC_PER_US;
  localparam int MIN_CYC   = MIN_US * CYC_PER_US;
  localparam int SPAN_CYC  = SPAN_US * CYC_PER_US;
  localparam int KICK_CYC  = KICK_US * CYC_PER_US;
  localparam int STEP_CYC  = STEP_US * CYC_PER_US;

  logic [WW-1:0] cnt;
  logic          frame_end;
  logic [WW-1:0] tgt;
  logic [WW-1:0] width;
  esc_phase_e    phase;
  logic          timer_run;
  logic          pulse_q;

  assign timer_run = en_i && (phase != PH_OFF);

  esc_frame_timer #(
    .FRAME_CYC (FRAME_CYC),
    .WW        (WW)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (timer_run),
    .cnt_o  (cnt),
    .last_o (frame_end)
  );

  esc_throttle_map #(
    .MIN_CYC  (MIN_CYC),
    .SPAN_CYC (SPAN_CYC),
    .WW       (WW)
  ) u_map (
    .clk   (clk),
    .rst   (rst),
    .thr_i (throttle_i),
    .tgt_o (tgt)
  );

  esc_sequencer #(
    .NEUT_CYC    (MIN_CYC),
    .KICK_CYC    (KICK_CYC),
    .STEP_CYC    (STEP_CYC),
    .ARM_FRAMES  (ARM_FRAMES),
    .KICK_FRAMES (KICK_FRAMES),
    .WW          (WW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .frame_end_i (frame_end),
    .tgt_i       (tgt),
    .phase_o     (phase),
    .width_o     (width),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= timer_run && (cnt < width);
  end

  assign pulse_o = pulse_q;
  assign width_o = width;

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pulse_o);

  a_r10_busy_phase: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ((phase == PH_ARM) || (phase == PH_KICK)));

  a_r1_rise_at_frame_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> (cnt == WW'(1)));
endmodule

// File: tb/tb_esc_pulse_gen.sv
module tb_esc_pulse_gen;
  localparam int FR   = 64;
  localparam int MINW = 16;
  localparam int SPAN = 32;
  localparam int KW   = 40;
  localparam int STP  = 4;
  localparam int ARMF = 3;
  localparam int KF   = 2;
  localparam int WW   = $clog2(FR + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [7:0]    thr = 8'd0;
  logic          pulse_o;
  logic          busy_o;
  logic [WW-1:0] width_o;

  esc_pulse_gen #(
    .CYC_PER_US (1), .FRAME_US (FR), .MIN_US (MINW), .SPAN_US (SPAN),
    .KICK_US (KW), .STEP_US (STP), .ARM_FRAMES (ARMF), .KICK_FRAMES (KF)
  ) dut (
    .clk (clk), .rst (rst), .en_i (en), .throttle_i (thr),
    .pulse_o (pulse_o), .busy_o (busy_o), .width_o (width_o)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state: 1 arm, 2 kick, 3 run
  int m_ph, m_n, m_w, m_prev_ph;
  bit m_from_run;

  function automatic int tgt_of(int t);
    return MINW + (t * SPAN + 127) / 255;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(int t);
    int tg;
    tg = tgt_of(t);
    m_prev_ph = m_ph;
    case (m_ph)
      1: if (m_n == ARMF - 1) begin
           m_n = 0;
           m_from_run = 1'b0;
           if (tg > MINW) begin m_ph = 2; m_w = KW; end
           else begin m_ph = 3; m_w = MINW; end
         end else m_n++;
      2: if (m_n == KF - 1) begin
           m_n = 0; m_ph = 3; m_w = (tg < KW) ? tg : KW;
         end else m_n++;
      default:
         if (m_w == MINW && tg > MINW) begin
           m_ph = 2; m_w = KW; m_n = 0; m_from_run = 1'b1;
         end else if (tg > m_w) m_w = (tg - m_w > STP) ? m_w + STP : tg;
         else m_w = (m_w - tg > STP) ? m_w - STP : tg;
    endcase
  endtask

  function automatic int sched(int mode, int f);
    if (mode == 1) return 255;
    if (f < 2)   return 255;
    if (f < 16)  return 64;
    if (f < 26)  return 255;
    if (f < 41)  return 0;
    if (f < 297) return f - 41;
    return 200;
  endfunction

  task automatic get_pulse(output int w, output int rise, output int wr, output bit br);
    @(negedge clk);
    while (!pulse_o) @(negedge clk);
    rise = cyc;
    wr = int'(width_o);
    br = busy_o;
    w = 0;
    while (pulse_o) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic run(int mode, int nf);
    int w, rise, wr, prev_rise;
    bit br;
    string lab;
    prev_rise = 0;
    for (int f = 0; f < nf; f++) begin
      get_pulse(w, rise, wr, br);
      if (m_ph == 1)      lab = "R3";
      else if (m_ph == 2) lab = m_from_run ? "R7" : "R4";
      else if (m_prev_ph == 2) lab = "R5";
      else if (mode == 0 && f > 41 && f <= 297) lab = "R2";
      else lab = "R6";
      chk(w == m_w, lab, w, m_w);
      chk(wr == w, "R8", wr, w);
      chk(br == (m_ph != 3), "R10", int'(br), int'(m_ph != 3));
      if (f > 0) chk(rise - prev_rise == FR, "R1", rise - prev_rise, FR);
      prev_rise = rise;
      thr = 8'(sched(mode, f));
      model_step(sched(mode, f));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(pulse_o == 1'b0, "R11", int'(pulse_o), 0);
    chk(busy_o == 1'b0, "R11", int'(busy_o), 0);
    chk(int'(width_o) == MINW, "R11", int'(width_o), MINW);

    // first enable: arming with full throttle requested (ignored)
    thr = 8'd255;
    m_ph = 1; m_n = 0; m_w = MINW; m_prev_ph = 1; m_from_run = 1'b0;
    en = 1'b1;
    run(0, 306);

    // disable mid-run: line must stay low
    en = 1'b0;
    lows = 0;
    @(negedge clk);
    for (int i = 0; i < 3 * FR; i++) begin
      if (pulse_o) lows++;
      @(negedge clk);
    end
    chk(lows == 0, "R9", lows, 0);
    chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
    chk(int'(width_o) == MINW, "R9", int'(width_o), MINW);

    // re-enable restarts arming, then kick and ramp
    thr = 8'd255;
    m_ph = 1; m_n = 0; m_w = MINW; m_prev_ph = 1; m_from_run = 1'b0;
    en = 1'b1;
    run(1, 9);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule